// File: doc/BRIEF.md
# Pseudo-Random State Fault Injector

This block produces bit-flip masks that a fault-tolerance test rig XORs into the state registers of several state machines under test. A 16-bit linear feedback shift register decides when each fault happens and which bit it hits. The gap to the next fault is drawn so that, on average, one fault lands every `period` enabled clocks. The bit position is picked from a shared 16-position virtual word. A machine whose state word is n bits wide only sees positions below n, so it gets about n/16 of all faults.

Each target slot has two mask outputs. The synchronous mask is meant to be XORed into the next-state value before the state register. The asynchronous-style mask is meant to be XORed into the register output that the machine's logic sees. A single input picks which of the two paths carries the faults. One slot is reserved for the reference machine and never receives a fault. Another input picks single faults or double faults. A double fault flips two distinct positions in the same cycle.

Top module: `state_fault_injector`

## Requirements
- R1: While `rst_n` is low, every mask is zero. After reset the generator holds seed 16'hACE1 and a countdown of 198, so the first fault fires on the 199th enabled cycle.
- R2: The generator advances once per enabled cycle as next = (s >> 1) XOR (s[0] ? 16'hB400 : 0). It never reaches zero.
- R3: A fault fires in an enabled cycle whose countdown is zero. The countdown then reloads with (s * (2p - 1)) >> 16. Here s is the generator value in that cycle and p is `period`, with `period` = 0 standing for 199. In every other enabled cycle the countdown drops by one.
- R4: In single mode (`double_mode` = 0) the virtual word has exactly one set bit, at position s[3:0].
- R5: In double mode the virtual word also sets position s[7:4]. When s[7:4] equals s[3:0], it sets position s[3:0] XOR 1 instead, so exactly two bits are set.
- R6: Bit j of the virtual word goes to bit j of a target's mask only when j is below that target's width. Every other mask bit is zero. Default widths by slot: 16, 4, 8, 16.
- R7: `async_path`, sampled in the firing cycle, sends the fault to `async_mask` (1) or to `sync_mask` (0). The other mask stays zero.
- R8: The reference slot (slot 0, bits [15:0] of each mask) is always zero.
- R9: A mask is non-zero only in the cycle right after a firing cycle. It is zero in every other cycle.
- R10: While `inj_en` is low, no fault fires, all masks are zero, and the generator and countdown hold their values.
- R11: Over a long run the number of faults comes close to cycles/p. A target of width n gets close to n/16 of the single faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inj_en | input | 1 | Injection enable; low freezes the generator and the countdown |
| double_mode | input | 1 | 0: one bit per fault; 1: two distinct bits per fault |
| async_path | input | 1 | 0: faults go to the synchronous masks; 1: faults go to the asynchronous-style masks |
| period | input | 16 | Mean clocks per fault; 0 selects the default of 199 |
| sync_mask | output | 64 | Pre-register masks, 16 bits per target slot, slot 0 lowest |
| async_mask | output | 64 | Post-register masks, same layout |

## Verification
The countdown and the generator are updated at a clock edge, and the masks are registered at that same edge from the cycle's generator value. A mask is therefore due exactly one edge after its firing cycle and lasts one cycle. The bench keeps an arithmetic model of the generator, the countdown and the width masking, which it advances at each rising edge. It then compares every mask bit at the following falling edge, so each fault is checked in the one cycle where it must appear and every quiet cycle is checked for zero. Long runs at period 8 and 199 also compare the fault totals and the share each width receives against cycles/p and n/16.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
   // Galois right-shift step of the fault generator
   function automatic logic [15:0] galois_step16(input logic [15:0] s, input logic [15:0] taps);
      galois_step16 = {1'b0, s[15:1]} ^ (s[0] ? taps : 16'h0);
   endfunction
endpackage

// File: rtl/sfi_lfsr.sv
module sfi_lfsr #(
   parameter int unsigned       LW   = 16,
   parameter logic [LW-1:0]     TAPS = 16'hB400,
   parameter logic [LW-1:0]     SEED = 16'hACE1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [LW-1:0] state
);
   generate
      if (SEED == '0) begin : g_bad_seed
         $error("sfi_lfsr: SEED must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  state <= SEED;
      else if (en) state <= {1'b0, state[LW-1:1]} ^ (state[0] ? TAPS : '0);
   end

   // R2
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
   // R10
   lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(state));
endmodule

// File: rtl/sfi_interval.sv
module sfi_interval #(
   parameter int unsigned LW       = 16,
   parameter int unsigned PW       = 16,
   parameter int unsigned DEF_RATE = 199
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [PW-1:0] period,
   input  logic [LW-1:0] rnd,
   output logic          fire
);
   localparam int unsigned CW = PW + 1;

   generate
      if (DEF_RATE < 1 || DEF_RATE >= (64'd1 << PW)) begin : g_bad_rate
         $error("sfi_interval: DEF_RATE out of range");
      end
   endgenerate

   logic [CW-1:0]    cnt;
   logic [PW-1:0]    p_eff;
   logic [CW-1:0]    span;
   logic [LW+CW-1:0] prod;
   logic [CW-1:0]    reload;

   always_comb begin
      p_eff  = (period == '0) ? PW'(DEF_RATE) : period;
      span   = {p_eff, 1'b0} - CW'(1);
      prod   = {{CW{1'b0}}, rnd} * {{LW{1'b0}}, span};
      reload = CW'(prod >> LW);
   end

   assign fire = en && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= CW'(DEF_RATE - 1);
      else if (fire) cnt <= reload;
      else if (en)   cnt <= cnt - CW'(1);
   end

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cnt != '0) |=> cnt == $past(cnt) - CW'(1));
   // R10
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(cnt));
endmodule

// File: rtl/sfi_position.sv
module sfi_position #(
   parameter int unsigned VW = 16
) (
   input  logic [2*$clog2(VW)-1:0] idx,
   input  logic                    dbl,
   output logic [VW-1:0]           vword
);
   localparam int unsigned PIDX = $clog2(VW);

   generate
      if ((1 << PIDX) != VW) begin : g_bad_vw
         $error("sfi_position: VW must be a power of two");
      end
   endgenerate

   logic [PIDX-1:0] pa, pb;

   always_comb begin
      pa = idx[PIDX-1:0];
      pb = idx[2*PIDX-1:PIDX];
      if (pb == pa) pb = pa ^ PIDX'(1);
      vword = VW'(1) << pa;
      if (dbl) vword = vword | (VW'(1) << pb);
   end
endmodule

// File: rtl/state_fault_injector.sv
module state_fault_injector #(
   parameter int unsigned NUM_TGT          = 4,
   parameter int unsigned TGT_W [NUM_TGT]  = '{16, 4, 8, 16},
   parameter int unsigned REF_SLOT         = 0,
   parameter int unsigned VW               = 16,
   parameter int unsigned LW               = 16,
   parameter int unsigned PW               = 16,
   parameter int unsigned DEF_RATE         = 199,
   parameter logic [LW-1:0] TAPS           = 16'hB400,
   parameter logic [LW-1:0] SEED           = 16'hACE1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  inj_en,
   input  logic                  double_mode,
   input  logic                  async_path,
   input  logic [PW-1:0]         period,
   output logic [NUM_TGT*VW-1:0] sync_mask,
   output logic [NUM_TGT*VW-1:0] async_mask
);
   localparam int unsigned PIDX = $clog2(VW);

   generate
      if (NUM_TGT < 1 || REF_SLOT >= NUM_TGT) begin : g_bad_slots
         $error("state_fault_injector: bad slot configuration");
      end
      if (LW < 2 * PIDX) begin : g_bad_lw
         $error("state_fault_injector: generator too narrow for two indices");
      end
   endgenerate

   logic [LW-1:0] rnd;
   logic          fire;
   logic [VW-1:0] vword;

   sfi_lfsr #(.LW(LW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
      .clk(clk), .rst_n(rst_n), .en(inj_en), .state(rnd));

   sfi_interval #(.LW(LW), .PW(PW), .DEF_RATE(DEF_RATE)) u_interval (
      .clk(clk), .rst_n(rst_n), .en(inj_en), .period(period), .rnd(rnd), .fire(fire));

   sfi_position #(.VW(VW)) u_position (
      .idx(rnd[2*PIDX-1:0]), .dbl(double_mode), .vword(vword));

   generate
      for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
         if (TGT_W[t] < 1 || TGT_W[t] > VW) begin : g_bad_w
            $error("state_fault_injector: target width out of range");
         end
         localparam logic [VW-1:0] WMASK =
            (t == REF_SLOT) ? '0 : VW'((64'd1 << TGT_W[t]) - 64'd1);
         logic [VW-1:0] sq, aq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sq <= '0;
               aq <= '0;
            end else begin
               sq <= (fire && !async_path) ? (vword & WMASK) : '0;
               aq <= (fire &&  async_path) ? (vword & WMASK) : '0;
            end
         end
         assign sync_mask[t*VW +: VW]  = sq;
         assign async_mask[t*VW +: VW] = aq;
      end
   endgenerate

   // R4 R5
   bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $countones(vword) == (double_mode ? 2 : 1));
   // R9
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|sync_mask) || (|async_mask)) |-> $past(fire));
   // R7
   path_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !((|sync_mask) && (|async_mask)));
endmodule

// File: tb/state_fault_injector_tb.sv
module state_fault_injector_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NT = 4;
   localparam int  BW [NT] = '{16, 4, 8, 16};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inj_en = 1'b0;
   logic        double_mode = 1'b0;
   logic        async_path = 1'b0;
   logic [15:0] period = 16'd0;
   logic [63:0] sync_mask, async_mask;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   state_fault_injector dut_i (
      .clk(clk), .rst_n(rst_n), .inj_en(inj_en), .double_mode(double_mode),
      .async_path(async_path), .period(period),
      .sync_mask(sync_mask), .async_mask(async_mask));

   // Arithmetic model built from the requirements
   logic [15:0] m_s;
   logic [16:0] m_c;
   logic [63:0] e_s, e_a;
   longint      pe, span, rel;
   int          pa, pb;
   logic [15:0] v;
   logic [63:0] acc;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s <= 16'hACE1;
         m_c <= 17'd198;
         e_s <= '0;
         e_a <= '0;
      end else if (inj_en) begin
         m_s <= {1'b0, m_s[15:1]} ^ (m_s[0] ? 16'hB400 : 16'h0);
         if (m_c == 0) begin
            pe   = (period == 0) ? 199 : longint'(period);
            span = 2 * pe - 1;
            rel  = (longint'(m_s) * span) >> 16;
            m_c <= 17'(rel);
            pa = int'(m_s[3:0]);
            pb = int'(m_s[7:4]);
            if (pb == pa) pb = pa ^ 1;
            v = 16'(1 << pa);
            if (double_mode) v = v | 16'(1 << pb);
            acc = '0;
            for (int t = 1; t < NT; t++)
               acc[t*16 +: 16] = v & 16'((1 << BW[t]) - 1);
            e_s <= async_path ? 64'h0 : acc;
            e_a <= async_path ? acc : 64'h0;
         end else begin
            m_c <= m_c - 17'd1;
            e_s <= '0;
            e_a <= '0;
         end
      end else begin
         e_s <= '0;
         e_a <= '0;
      end
   end

   task automatic check64(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic check_range(input string req, input string what, input int got, input int lo, input int hi);
      checks++;
      if (got < lo || got > hi) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, got, lo, hi);
      end
   endtask

   int tot_faults, slot1_hits, last_fires;

   // compare every mask bit at the falling edge after each rising edge
   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check64(cur_req, "sync_mask", sync_mask, e_s);
         check64(cur_req, "async_mask", async_mask, e_a);
         // R8 reference slot
         check64("R8", "ref slot", {48'h0, sync_mask[15:0] | async_mask[15:0]}, 64'h0);
         if (|(sync_mask[63:48] | async_mask[63:48])) tot_faults++;
         if (|(sync_mask[31:16] | async_mask[31:16])) slot1_hits++;
      end
   endtask

   task automatic main_seq();
      // R1 reset state
      repeat (3) @(negedge clk);
      check64("R1", "sync in reset", sync_mask, 64'h0);
      check64("R1", "async in reset", async_mask, 64'h0);
      rst_n = 1'b1;
      inj_en = 1'b1;
      // R1 R2 R3 first fault at default rate
      cur_req = "R1 R2 R3";
      tot_faults = 0;
      run(199);
      check_range("R1", "faults before 199th cycle", tot_faults, 1, 1);
      // R4 R6 R7 R9 R11 single sync, period 8
      cur_req = "R4 R6 R7 R9";
      period = 16'd8;
      tot_faults = 0; slot1_hits = 0;
      run(20000);
      check_range("R11", "fault total at p=8", tot_faults, 2000, 3000);
      check_range("R11", "width-4 share", slot1_hits, tot_faults * 4 / 16 - 150, tot_faults * 4 / 16 + 150);
      // R5 R7 double async, period 199
      cur_req = "R5 R7 R9";
      double_mode = 1'b1;
      async_path = 1'b1;
      period = 16'd199;
      tot_faults = 0;
      run(20000);
      check_range("R11", "fault total at p=199", tot_faults, 70, 135);
      // R3 period 1: a fault every cycle once the old countdown runs out
      cur_req = "R3 R5";
      period = 16'd1;
      run(500);
      tot_faults = 0;
      run(300);
      check_range("R3", "faults at p=1", tot_faults, 300, 300);
      // R3 period 0 selects the default rate
      cur_req = "R3 R4";
      double_mode = 1'b0;
      async_path = 1'b0;
      period = 16'd0;
      run(3000);
      // R10 disable: zero masks, state held (the model resumes afterwards)
      cur_req = "R10";
      inj_en = 1'b0;
      tot_faults = 0;
      run(600);
      check_range("R10", "faults while disabled", tot_faults, 0, 0);
      inj_en = 1'b1;
      cur_req = "R10 R2 R3";
      period = 16'd3;
      run(2000);
      cur_req = "R3 R6";
      period = 16'hFFFF;
      double_mode = 1'b1;
      run(1500);
   endtask

   initial begin
      fork
         main_seq();
         begin
            repeat (100000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule